// File: doc/BRIEF.md
# Peripheral Power-Up and Reset Sequencer

This block brings an external chip from cold to running, and takes it back down, by driving four control lines in a fixed order with timed waits between them. The control lines are a supply enable that covers both rails, a 32 kHz clock enable, a power-up line, and an active-low chip reset. Every wait is counted in pulses of a one-millisecond strobe that comes from outside the block. Each wait length is a parameter, so a short configuration can be used for testing and the real values can be used in silicon.

The power-on order is as follows. First there is a settle wait with every line low. Then the supply is enabled, and the block waits until supply-good is seen. Then the clock is enabled, the block waits until clock-good is seen, and a clock-stabilisation wait follows. Then the power-up line is raised and held. Then reset is released, and a final wait passes before the chip is reported ready. If supply-good or clock-good does not rise within a timeout, the sequence stops, every line drops, and fault is reported. The power-off order asserts reset first and holds it. It then drops the supply and the power-up line, and it drops the clock one cycle later.

The block accepts only two commands. A start command is taken when the block is idle, and a stop command is taken when the block is ready. Any other command is ignored.

Top module: `pwr_seq`

## Requirements
- R1: While the block is in reset and after it, supply_en, clk32_en, power_up and chip_rst_n are low, and busy, ready and fault are low.
- R2: cmd_on is accepted only in the idle state, including idle after a fault. The sequence then holds all four lines low for SETTLE_MS strobe pulses. A wait of N pulses ends at the clock edge that samples the Nth tick_ms pulse counted within that step.
- R3: After the settle wait, supply_en rises alone. The sequence moves on at the first edge that samples supply_good high. If GOOD_TMO_MS pulses pass in this step without supply_good, a fault is raised and clk32_en never rises.
- R4: clk32_en rises only after supply_good has been sampled high. The sequence moves on at the first edge that samples clock_good high, or faults after GOOD_TMO_MS pulses without it. After clock_good, a stabilisation wait of CLKSTAB_MS pulses follows.
- R5: power_up then rises and is held for PWRUP_MS pulses. chip_rst_n then rises, and after RELEASE_MS pulses ready rises. Written as {supply_en, clk32_en, power_up, chip_rst_n}, the output vector therefore steps 1000, 1100, 1110, 1111.
- R6: On a fault, all four lines go low and fault stays high until the next accepted cmd_on clears it.
- R7: cmd_off is accepted only when the block is ready. chip_rst_n falls first and stays low for RSTHOLD_MS pulses. Then supply_en and power_up fall, and clk32_en falls one cycle later. The vector steps 1110, 0100, 0000.
- R8: cmd_on and cmd_off are ignored while busy. cmd_off is ignored when idle, and cmd_on is ignored when ready.
- R9: busy is high from the edge that accepts a command until the final wait of that sequence ends, or until a fault. ready and busy are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| tick_ms | input | 1 | One-cycle strobe, once per millisecond |
| cmd_on | input | 1 | Start the power-on sequence |
| cmd_off | input | 1 | Start the power-off sequence |
| supply_good | input | 1 | Both rails are in regulation |
| clock_good | input | 1 | 32 kHz clock is running |
| supply_en | output | 1 | Enable for both supply rails |
| clk32_en | output | 1 | Enable for the 32 kHz clock |
| power_up | output | 1 | Power-up line to the chip |
| chip_rst_n | output | 1 | Active-low reset to the chip |
| busy | output | 1 | A sequence is running |
| ready | output | 1 | The chip is up and out of reset |
| fault | output | 1 | The last power-on attempt failed |

## Verification
The bench sweeps the delays of supply-good and clock-good across a grid. Short and medium delays show that the block waits on each input and moves on as soon as that input is seen. A delay longer than the timeout shows which enable step failed, because the later enables must never appear. For each step, the bench counts the strobe pulses that pass in that step and compares the count with the parameter. Stray start and stop pulses are injected during every sequence and in the idle and ready states, and they must leave both the counts and the output order unchanged.

// File: rtl/pwr_seq.sv
module pwr_seq #(
  parameter int SETTLE_MS   = 10,
  parameter int CLKSTAB_MS  = 10,
  parameter int PWRUP_MS    = 250,
  parameter int RELEASE_MS  = 50,
  parameter int RSTHOLD_MS  = 30,
  parameter int GOOD_TMO_MS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_ms,
  input  logic cmd_on,
  input  logic cmd_off,
  input  logic supply_good,
  input  logic clock_good,
  output logic supply_en,
  output logic clk32_en,
  output logic power_up,
  output logic chip_rst_n,
  output logic busy,
  output logic ready,
  output logic fault
);
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAXT = mx(mx(mx(SETTLE_MS, CLKSTAB_MS), mx(PWRUP_MS, RELEASE_MS)),
                           mx(RSTHOLD_MS, GOOD_TMO_MS));
  localparam int CW = $clog2(MAXT + 1);

  typedef enum logic [3:0] {
    S_OFF, S_SETTLE, S_SUP, S_CLK, S_STAB, S_PWR, S_REL, S_RDY, S_HOLD, S_DROP
  } st_t;

  st_t st, nxt;
  logic [CW-1:0] cnt, lim;
  logic fault_q, done, fail, timed;

  always_comb begin
    case (st)
      S_SETTLE:     lim = CW'(SETTLE_MS);
      S_SUP, S_CLK: lim = CW'(GOOD_TMO_MS);
      S_STAB:       lim = CW'(CLKSTAB_MS);
      S_PWR:        lim = CW'(PWRUP_MS);
      S_REL:        lim = CW'(RELEASE_MS);
      S_HOLD:       lim = CW'(RSTHOLD_MS);
      default:      lim = CW'(1);
    endcase
  end

  assign timed = st inside {S_SETTLE, S_SUP, S_CLK, S_STAB, S_PWR, S_REL, S_HOLD};
  assign done  = timed && tick_ms && (cnt == lim - 1'b1);
  assign fail  = (st == S_SUP && !supply_good && done) ||
                 (st == S_CLK && !clock_good && done);

  always_comb begin
    nxt = st;
    case (st)
      S_OFF:    if (cmd_on) nxt = S_SETTLE;
      S_SETTLE: if (done) nxt = S_SUP;
      S_SUP:    if (supply_good) nxt = S_CLK; else if (done) nxt = S_OFF;
      S_CLK:    if (clock_good) nxt = S_STAB; else if (done) nxt = S_OFF;
      S_STAB:   if (done) nxt = S_PWR;
      S_PWR:    if (done) nxt = S_REL;
      S_REL:    if (done) nxt = S_RDY;
      S_RDY:    if (cmd_off) nxt = S_HOLD;
      S_HOLD:   if (done) nxt = S_DROP;
      S_DROP:   nxt = S_OFF;
      default:  nxt = S_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_OFF;
      cnt     <= '0;
      fault_q <= 1'b0;
    end else begin
      st <= nxt;
      if (nxt != st)            cnt <= '0;
      else if (timed && tick_ms) cnt <= cnt + 1'b1;
      if (fail)                         fault_q <= 1'b1;
      else if (st == S_OFF && cmd_on)   fault_q <= 1'b0;
    end
  end

  assign supply_en  = st inside {S_SUP, S_CLK, S_STAB, S_PWR, S_REL, S_RDY, S_HOLD};
  assign clk32_en   = st inside {S_CLK, S_STAB, S_PWR, S_REL, S_RDY, S_HOLD, S_DROP};
  assign power_up   = st inside {S_PWR, S_REL, S_RDY, S_HOLD};
  assign chip_rst_n = st inside {S_REL, S_RDY};
  assign ready      = (st == S_RDY);
  assign busy       = !(st == S_OFF || st == S_RDY);
  assign fault      = fault_q;

  AST_RELEASE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rst_n |-> (supply_en && clk32_en && power_up)); // R5
  AST_CLK_AFTER_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk32_en) |-> $past(supply_good)); // R4
  AST_FAULT_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !(supply_en || clk32_en || power_up || chip_rst_n || busy)); // R6
  AST_FAULT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault) |-> busy); // R6
  AST_RESET_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(supply_en) |-> $past(!chip_rst_n)); // R7
  AST_CLK_DROPS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk32_en) |-> !supply_en); // R7
  AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && busy)); // R9
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (ready || !(supply_en || clk32_en || power_up || chip_rst_n))); // R9
endmodule

// File: tb/pwr_seq_tb_top.sv
module pwr_seq_tb_top;
  localparam int P_SET = 2, P_STAB = 3, P_PWR = 5, P_REL = 4, P_HOLD = 3, P_TMO = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, tick_ms = 1'b0, cmd_on = 1'b0, cmd_off = 1'b0;
  logic supply_good = 1'b0, clock_good = 1'b0;
  logic supply_en, clk32_en, power_up, chip_rst_n, busy, ready, fault;

  pwr_seq #(.SETTLE_MS(P_SET), .CLKSTAB_MS(P_STAB), .PWRUP_MS(P_PWR),
            .RELEASE_MS(P_REL), .RSTHOLD_MS(P_HOLD), .GOOD_TMO_MS(P_TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .cmd_on(cmd_on), .cmd_off(cmd_off),
    .supply_good(supply_good), .clock_good(clock_good), .supply_en(supply_en),
    .clk32_en(clk32_en), .power_up(power_up), .chip_rst_n(chip_rst_n),
    .busy(busy), .ready(ready), .fault(fault));

  int nchk = 0, nfail = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int ds = 0, dc = 0, sc = 0, cc = 0, tph = 0, oidx = 0;
  int c_set = 0, c_stab = 0, c_pwr = 0, c_rel = 0, c_hold = 0;
  bit offm = 0, frun = 0, saw_clk = 0, saw_pwr = 0, bp = 0, cgp = 0;
  logic [3:0] vp = 4'b0000, v;

  function automatic logic [3:0] exp_on(input int i);
    case (i) 0: return 4'b1000; 1: return 4'b1100; 2: return 4'b1110; default: return 4'b1111; endcase
  endfunction
  function automatic logic [3:0] exp_off(input int i);
    case (i) 0: return 4'b1110; 1: return 4'b0100; default: return 4'b0000; endcase
  endfunction

  always @(negedge clk) begin
    v = {supply_en, clk32_en, power_up, chip_rst_n};
    if (tick_ms) begin
      if (!offm) begin
        if (vp == 4'b0000 && bp) c_set++;
        if (vp == 4'b1100 && clock_good && cgp) c_stab++;
        if (vp == 4'b1110) c_pwr++;
        if (vp == 4'b1111 && bp) c_rel++;
      end else if (vp == 4'b1110) c_hold++;
    end
    cgp = clock_good;
    if (v != vp) begin
      if (!offm) begin
        if (!(frun && v == 4'b0000)) begin
          chk(v == exp_on(oidx), "R5 on-order", int'(v), int'(exp_on(oidx)));
          oidx++;
        end
      end else begin
        chk(v == exp_off(oidx), "R7 off-order", int'(v), int'(exp_off(oidx)));
        oidx++;
      end
    end
    if (v[2]) saw_clk = 1;
    if (v[1]) saw_pwr = 1;
    chk(!(busy && ready), "R9 ready with busy", int'(busy), 0);
    vp = v;
    bp = busy;
    sc = supply_en ? sc + 1 : 0;
    supply_good = supply_en && (sc > ds);
    cc = clk32_en ? cc + 1 : 0;
    clock_good = clk32_en && (cc > dc);
    tph = (tph + 1) % 4;
    tick_ms = (tph == 0);
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wait_idle(input string req);
    for (int k = 0; k < 600 && busy; k++) begin
      chk(!ready, req, int'(ready), 0);
      step();
    end
  endtask

  task automatic run_on(input int a, input int b);
    step();
    ds = a; dc = b; frun = (a > 20) || (b > 20);
    c_set = 0; c_stab = 0; c_pwr = 0; c_rel = 0; oidx = 0; offm = 0;
    saw_clk = 0; saw_pwr = 0;
    cmd_on = 1; step(); cmd_on = 0;
    chk(busy == 1'b1, "R9 busy after on", int'(busy), 1);
    chk(fault == 1'b0, "R6 fault cleared by on", int'(fault), 0);
    repeat (6) step();
    chk(busy == 1'b1, "R8 still busy at stray pulse", int'(busy), 1);
    cmd_on = 1; cmd_off = 1; step(); cmd_on = 0; cmd_off = 0;
    wait_idle("R9 ready during on");
    if (frun) begin
      chk(fault == 1'b1, "R6 fault set", int'(fault), 1);
      chk({supply_en, clk32_en, power_up, chip_rst_n} == 4'b0000, "R6 lines low",
          int'({supply_en, clk32_en, power_up, chip_rst_n}), 0);
      chk(ready == 1'b0, "R6 not ready", int'(ready), 0);
      if (a > 20) chk(!saw_clk, "R3 clock never enabled", int'(saw_clk), 0);
      else        chk(!saw_pwr, "R4 power_up never raised", int'(saw_pwr), 0);
    end else begin
      chk(ready == 1'b1, "R5 ready", int'(ready), 1);
      chk(fault == 1'b0, "R5 no fault", int'(fault), 0);
      chk(c_set == P_SET, "R2 settle ticks", c_set, P_SET);
      chk(c_stab == P_STAB, "R4 stabilise ticks", c_stab, P_STAB);
      chk(c_pwr == P_PWR, "R5 power_up ticks", c_pwr, P_PWR);
      chk(c_rel == P_REL, "R5 release ticks", c_rel, P_REL);
      chk(oidx == 4, "R5 step count", oidx, 4);
      cmd_on = 1; step(); cmd_on = 0;
      repeat (3) step();
      chk(ready == 1'b1 && busy == 1'b0, "R8 on ignored when ready", int'(ready), 1);
    end
  endtask

  task automatic run_off();
    step();
    offm = 1; oidx = 0; c_hold = 0;
    cmd_off = 1; step(); cmd_off = 0;
    chk(busy == 1'b1 && chip_rst_n == 1'b0, "R7 reset first", int'(chip_rst_n), 0);
    repeat (3) step();
    cmd_on = 1; step(); cmd_on = 0;
    wait_idle("R9 ready during off");
    chk({supply_en, clk32_en, power_up, chip_rst_n} == 4'b0000, "R7 all off",
        int'({supply_en, clk32_en, power_up, chip_rst_n}), 0);
    chk(ready == 1'b0, "R7 not ready", int'(ready), 0);
    chk(c_hold == P_HOLD, "R7 reset hold ticks", c_hold, P_HOLD);
    chk(oidx == 3, "R7 step count", oidx, 3);
    cmd_off = 1; step(); cmd_off = 0;
    repeat (4) step();
    chk(busy == 1'b0 && supply_en == 1'b0, "R8 off ignored when idle", int'(busy), 0);
  endtask

  initial begin
    int dl[4] = '{1, 3, 6, 30};
    repeat (3) step();
    chk({supply_en, clk32_en, power_up, chip_rst_n, busy, ready, fault} == 7'd0,
        "R1 in reset", int'({supply_en, clk32_en, power_up, chip_rst_n, busy, ready, fault}), 0);
    rst_n = 1;
    repeat (3) step();
    chk({supply_en, clk32_en, power_up, chip_rst_n, busy, ready, fault} == 7'd0,
        "R1 after reset", int'({supply_en, clk32_en, power_up, chip_rst_n, busy, ready, fault}), 0);
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        run_on(dl[i], dl[j]);
        if (!frun) run_off();
      end
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done_flag) begin
      done_flag = 1;
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule